// File: doc/BRIEF.md
# Pulse-Domain Phase Subtractor

This block subtracts a digital feedback value from the width of an incoming pulse, and it does the subtraction in time rather than on numbers. Widths are counted in ticks of the block clock. On each rising edge of the input pulse, the block captures the feedback value and starts a reference pulse that lasts exactly that many ticks. A set/reset flag holds the reference, and a down-counter ends it.

The block compares the input with the reference and drives two separate outputs. The positive output is high while the input is high and the reference is low, so its width is the amount by which the input is longer than the feedback. The negative output is high while the reference is high and the input is low, so its width is the amount by which the input is shorter. A later stage, typically a pair of time quantizers, measures each path.

Top module: `pulse_phase_subtractor`

## Requirements
- R1: During reset and on the first cycle after it, `out_p` and `out_n` are 0. An active-low reset applied while a reference is running ends that reference: both outputs are 0 from the next sampled cycle on.
- R2: `fb` is captured at the clock edge that sees a rising edge of `in_pulse`. Changing `fb` while a reference is running has no effect on its length.
- R3: The reference pulse lasts exactly `fb` clock cycles, including the largest value `2**FB_W-1`.
- R4: When the input stays high for W cycles and W > fb, `out_p` is high for exactly W-fb cycles and `out_n` stays low.
- R5: When the input stays high for W cycles and fb > W, `out_n` is high for exactly fb-W cycles and `out_p` stays low.
- R6: With `fb` = 0 no reference is produced, and `out_p` reproduces the input: it is high for W cycles.
- R7: `out_p` and `out_n` are never high in the same cycle.
- R8: A rising edge of `in_pulse` that comes while a reference is running restarts it with the newly captured `fb`. This holds even in the very cycle the old reference would have ended.
- R9: When W equals fb, both outputs stay low for the whole pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; all pulse widths are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_pulse | input | 1 | Input pulse whose width is measured |
| fb | input | FB_W | Unsigned feedback value in ticks, captured on the input's rising edge |
| out_p | output | 1 | High while the input exceeds the reference |
| out_n | output | 1 | High while the reference exceeds the input |

## Verification
Two events can land in the same cycle. In the first, a new rising edge of the input arrives exactly when the running reference's counter reaches its last tick. The bench provokes this with a feedback of 3, a one-tick pulse, and a second rise three ticks later. The restart must win, which shows as four ticks of `out_n` and none of `out_p`. In the second, the input falls in the same cycle the reference ends (W equal to fb). This is judged by both outputs staying silent for the whole pulse.

// File: rtl/psub_pkg.sv
package psub_pkg;
   // Which side of the comparison currently leads.
   typedef enum logic [1:0] {
      LEAD_NONE = 2'b00,
      LEAD_IN   = 2'b01,
      LEAD_REF  = 2'b10
   } lead_e;

   function automatic lead_e classify(input logic in_hi, input logic ref_hi);
      if (in_hi && !ref_hi)      return LEAD_IN;
      else if (ref_hi && !in_hi) return LEAD_REF;
      else                       return LEAD_NONE;
   endfunction
endpackage

// File: rtl/psub_edge.sv
module psub_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic in_pulse,
   output logic in_q,
   output logic rise
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_q <= 1'b0;
      else        in_q <= in_pulse;
   end

   assign rise = in_pulse & ~in_q;

   // R1: first cycle after reset the registered input is clear
   assert_in_q_reset_R1: assert property (@(posedge clk)
      !rst_n |=> !in_q);
endmodule

// File: rtl/psub_refgen.sv
module psub_refgen #(
   parameter int FB_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [FB_W-1:0] fb,
   output logic            ref_q
);
   localparam logic [FB_W-1:0] LAST_TICK = FB_W'(1);

   logic [FB_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
         ref_q  <= 1'b0;
      end else if (start) begin
         remain <= fb;
         ref_q  <= (fb != '0);
      end else if (ref_q) begin
         remain <= remain - LAST_TICK;
         if (remain == LAST_TICK) ref_q <= 1'b0;
      end
   end

   // R6: zero feedback never raises the reference
   assert_zero_fb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && fb == '0) |=> !ref_q);
   // R8: any edge with non-zero feedback (re)starts the reference
   assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && fb != '0) |=> ref_q);
   // R3: the reference does not end before its last tick
   assert_no_early_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_q && !start && remain != LAST_TICK) |=> ref_q);
   // R1: reset clears the reference
   assert_ref_reset_R1: assert property (@(posedge clk)
      !rst_n |=> !ref_q);
endmodule

// File: rtl/psub_compare.sv
module psub_compare #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_hi,
   input  logic ref_hi,
   output logic out_p,
   output logic out_n
);
   import psub_pkg::*;

   lead_e lead;
   assign lead = classify(in_hi, ref_hi);

   generate
      if (REG_OUT) begin : g_reg
         logic p_q, n_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               p_q <= 1'b0;
               n_q <= 1'b0;
            end else begin
               p_q <= (lead == LEAD_IN);
               n_q <= (lead == LEAD_REF);
            end
         end
         assign out_p = p_q;
         assign out_n = n_q;
      end else begin : g_comb
         assign out_p = (lead == LEAD_IN);
         assign out_n = (lead == LEAD_REF);
      end
   endgenerate

   // R7: the two paths never overlap
   assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_p && out_n));
endmodule

// File: rtl/pulse_phase_subtractor.sv
module pulse_phase_subtractor #(
   parameter int FB_W    = 8,
   parameter bit REG_OUT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_pulse,
   input  logic [FB_W-1:0] fb,
   output logic            out_p,
   output logic            out_n
);
   generate
      if (FB_W < 1 || FB_W > 24) begin : g_bad_width
         $error("pulse_phase_subtractor: FB_W must lie in 1..24");
      end
   endgenerate

   logic in_q, rise, ref_q;

   psub_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_pulse (in_pulse),
      .in_q     (in_q),
      .rise     (rise)
   );

   psub_refgen #(.FB_W(FB_W)) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .start (rise),
      .fb    (fb),
      .ref_q (ref_q)
   );

   psub_compare #(.REG_OUT(REG_OUT)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_hi  (in_q),
      .ref_hi (ref_q),
      .out_p  (out_p),
      .out_n  (out_n)
   );

   // R9: while input and reference are both high nothing leads
   assert_equal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_q && ref_q && !REG_OUT) |-> (!out_p && !out_n));
endmodule

// File: tb/sim_pulse_phase_subtractor.sv
module sim_pulse_phase_subtractor;
   localparam int FB_W = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_pulse = 1'b0;
   logic [FB_W-1:0] fb = '0;
   logic            out_p, out_n;

   int n_checks = 0;
   int n_fail   = 0;
   int p_cnt = 0, n_cnt = 0, both_cnt = 0;

   always #10 clk = ~clk;

   pulse_phase_subtractor #(.FB_W(FB_W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_pulse(in_pulse), .fb(fb),
      .out_p(out_p), .out_n(out_n)
   );

   always @(negedge clk) begin
      p_cnt    <= p_cnt + int'(out_p);
      n_cnt    <= n_cnt + int'(out_n);
      both_cnt <= both_cnt + int'(out_p && out_n);
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clear_counts();
      @(negedge clk);
      p_cnt = 0; n_cnt = 0; both_cnt = 0;
   endtask

   task automatic idle(input int cycles);
      for (int i = 0; i < cycles; i++) @(negedge clk);
   endtask

   task automatic single_pulse(input int w, input int fbv);
      clear_counts();
      fb = FB_W'(fbv);
      in_pulse = 1'b1;
      idle(w);
      in_pulse = 1'b0;
      idle(fbv + w + 6);
   endtask

   task automatic expect_counts(input string tag, input int ep, input int en);
      check(p_cnt == ep, {tag, " out_p width"}, p_cnt, ep);
      check(n_cnt == en, {tag, " out_n width"}, n_cnt, en);
      check(both_cnt == 0, "R7 overlap", both_cnt, 0);
   endtask

   task automatic t_reset();
      idle(2);
      check(out_p == 1'b0, "R1 out_p in reset", int'(out_p), 0);
      check(out_n == 1'b0, "R1 out_n in reset", int'(out_n), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_p == 1'b0 && out_n == 1'b0, "R1 after release", int'({out_p, out_n}), 0);
   endtask

   task automatic t_positive();
      single_pulse(6, 2);
      expect_counts("R4", 4, 0);
   endtask

   task automatic t_negative();
      single_pulse(2, 5);
      expect_counts("R5", 0, 3);
   endtask

   task automatic t_zero_fb();
      single_pulse(4, 0);
      expect_counts("R6", 4, 0);
   endtask

   task automatic t_equal();
      single_pulse(3, 3);
      expect_counts("R9", 0, 0);
   endtask

   task automatic t_max_fb();
      single_pulse(1, 255);
      expect_counts("R3 max fb", 0, 254);
   endtask

   task automatic t_fb_change();
      clear_counts();
      fb = FB_W'(5);
      in_pulse = 1'b1;
      idle(1);
      fb = FB_W'(1);
      idle(1);
      in_pulse = 1'b0;
      idle(12);
      expect_counts("R2 fb held", 0, 3);
   endtask

   task automatic t_restart();
      clear_counts();
      fb = FB_W'(6);
      in_pulse = 1'b1; idle(2);
      in_pulse = 1'b0; idle(2);
      in_pulse = 1'b1; idle(2);
      in_pulse = 1'b0; idle(14);
      expect_counts("R8 restart", 0, 6);
   endtask

   task automatic t_restart_last_tick();
      clear_counts();
      fb = FB_W'(3);
      in_pulse = 1'b1; idle(1);
      in_pulse = 1'b0; idle(2);
      in_pulse = 1'b1; idle(1);
      in_pulse = 1'b0; idle(10);
      expect_counts("R8 same-cycle restart", 0, 4);
   endtask

   task automatic t_reset_midway();
      clear_counts();
      fb = FB_W'(20);
      in_pulse = 1'b1; idle(2);
      in_pulse = 1'b0; idle(2);
      rst_n = 1'b0;
      @(negedge clk);
      check(out_n == 1'b0, "R1 reset kills reference", int'(out_n), 0);
      rst_n = 1'b1;
      clear_counts();
      idle(25);
      check(n_cnt == 0 && p_cnt == 0, "R1 nothing after reset", n_cnt + p_cnt, 0);
   endtask

   initial begin
      t_reset();
      t_positive();
      t_negative();
      t_zero_fb();
      t_equal();
      t_max_fb();
      t_fb_change();
      t_restart();
      t_restart_last_tick();
      t_reset_midway();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule